// File: doc/BRIEF.md
# Test Access Port with Long Identification Chain

This block is an IEEE 1149.1 style test access port controller. It is clocked by TCK and steered by TMS. It holds a 46-bit instruction register and a 197-bit data chain. When the controller enters Capture-DR, the data chain is filled with six 32-bit identification words. Each word sits at a fixed place in the chain. The two words nearest the output end sit one bit further along than a uniform 32-bit pitch would put them. A small revision input chooses one of several parameter sets of identification words. The block latches the scanned instruction and brings it out, but it does not decode it.

The controller has sixteen states. Each state code is given as state name = code, followed by the next state for TMS=0 and the next state for TMS=1:

- Test-Logic-Reset = 0: Run-Test/Idle, Test-Logic-Reset
- Run-Test/Idle = 1: Run-Test/Idle, Select-DR
- Select-DR = 2: Capture-DR, Select-IR
- Capture-DR = 3: Shift-DR, Exit1-DR
- Shift-DR = 4: Shift-DR, Exit1-DR
- Exit1-DR = 5: Pause-DR, Update-DR
- Pause-DR = 6: Pause-DR, Exit2-DR
- Exit2-DR = 7: Shift-DR, Update-DR
- Update-DR = 8: Run-Test/Idle, Select-DR
- Select-IR = 9: Capture-IR, Test-Logic-Reset
- Capture-IR = 10: Shift-IR, Exit1-IR
- Shift-IR = 11: Shift-IR, Exit1-IR
- Exit1-IR = 12: Pause-IR, Update-IR
- Pause-IR = 13: Pause-IR, Exit2-IR
- Exit2-IR = 14: Shift-IR, Update-IR
- Update-IR = 15: Run-Test/Idle, Select-IR

Each state's action (capture, shift or update) happens on the same rising edge of TCK that moves the controller into that state.

Top module: `jtag_tap_long`

## Requirements
- R1: While trst_n is low, the block is forced asynchronously into this reset state: tap_state is 0 (Test-Logic-Reset), instr is 0, the instruction register is 0 and tdo is 0.
- R2: On each rising TCK edge, tap_state moves to the successor given for the current TMS value in the state list above. The state codes are fixed as listed. Test-Logic-Reset stays put while TMS=1, and five TMS=1 edges reach it from any state.
- R3: The rising edge that enters Capture-IR loads the instruction register with the value 1, so that its two low bits are 01.
- R4: Each rising edge that enters or stays in Shift-IR does three things: it sends the instruction register's bit 0 toward tdo, it shifts the register right by one, and it takes tdi into bit 45.
- R5: The rising edge that enters Update-IR copies the 46-bit instruction register to instr. No other edge changes instr, and this includes a return to Test-Logic-Reset through TMS.
- R6: The rising edge that enters Capture-DR loads the 197-bit chain. It writes identification word k (k = 0..5) most significant bit first at chain positions P, P+1, ... P+31, where P is 1, 33, 65, 97, 130 or 162 for k = 0..5. Every other chain bit is cleared. rev selects the word set, and a rev value at or above the number of sets selects the last set.
- R7: Each rising edge that enters or stays in Shift-DR does three things: it sends chain bit 196 toward tdo, it moves every bit one position up, and it takes tdi into position 0. A bit shifted in at position 0 therefore reaches tdo after 197 more shifts.
- R8: tdo is registered and changes only on the falling TCK edge that follows a shifting rising edge. It then shows the bit sent by that edge. In every other state tdo holds its value.
- R9: The chain and the instruction register keep their contents through the Exit1, Pause and Exit2 states. Shifting resumes where it left off, with no recapture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| rev | input | REV_W | Identification word set select |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tap_state | output | 4 | Current controller state code |
| instr | output | IR_LEN | Current latched instruction |

## Verification
A new tap_state value is visible right after the rising TCK edge that causes it. The tdo bit sent by a shifting edge appears only after the next falling edge. instr changes on the edge that enters Update-IR. The driver stamps each expected item with the index of the rising edge it belongs to. The monitor samples two time units after each falling edge and pops only items whose edge has already happened. It therefore compares state and tdo exactly one falling edge after the edge under test. Direct checks of instr and of the asynchronous reset are made between edges, once the relevant edge has passed.

// File: rtl/tap_pkg.sv
package tap_pkg;

    typedef enum logic [3:0] {
        TS_RESET   = 4'd0,
        TS_IDLE    = 4'd1,
        TS_SEL_DR  = 4'd2,
        TS_CAP_DR  = 4'd3,
        TS_SH_DR   = 4'd4,
        TS_EX1_DR  = 4'd5,
        TS_PAU_DR  = 4'd6,
        TS_EX2_DR  = 4'd7,
        TS_UPD_DR  = 4'd8,
        TS_SEL_IR  = 4'd9,
        TS_CAP_IR  = 4'd10,
        TS_SH_IR   = 4'd11,
        TS_EX1_IR  = 4'd12,
        TS_PAU_IR  = 4'd13,
        TS_EX2_IR  = 4'd14,
        TS_UPD_IR  = 4'd15
    } tap_state_e;

    // strobes for the edge that enters the named state
    typedef struct packed {
        logic cap_ir;
        logic sh_ir;
        logic upd_ir;
        logic cap_dr;
        logic sh_dr;
    } tap_ctl_t;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_q,
    output tap_ctl_t   ctl
);

    tap_state_e nxt;

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:  nxt = tms ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:  nxt = tms ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SH_IR;
            TS_UPD_IR: nxt = tms ? TS_SEL_IR : TS_IDLE;
            default:   nxt = TS_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= TS_RESET;
        else         state_q <= nxt;
    end

    // actions are keyed on the state being entered
    always_comb begin
        ctl = '0;
        unique case (nxt)
            TS_CAP_IR: ctl.cap_ir = 1'b1;
            TS_SH_IR:  ctl.sh_ir  = 1'b1;
            TS_UPD_IR: ctl.upd_ir = 1'b1;
            TS_CAP_DR: ctl.cap_dr = 1'b1;
            TS_SH_DR:  ctl.sh_dr  = 1'b1;
            default:   ctl = '0;
        endcase
    end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
#(
    parameter int IR_LEN = 46
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tdi,
    input  tap_ctl_t          ctl,
    output logic [IR_LEN-1:0] ir_q,
    output logic [IR_LEN-1:0] instr
);

    localparam logic [IR_LEN-1:0] CAP_VAL = IR_LEN'(1);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_q  <= '0;
            instr <= '0;
        end else begin
            if (ctl.cap_ir)
                ir_q <= CAP_VAL;
            else if (ctl.sh_ir)
                ir_q <= {tdi, ir_q[IR_LEN-1:1]};
            if (ctl.upd_ir)
                instr <= ir_q;
        end
    end

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int DR_LEN  = 197,
    parameter int ID_W    = 32,
    parameter int NUM_ID  = 6,
    parameter int NUM_REV = 3,
    parameter int REV_W   = 2,
    parameter int unsigned ID_POS [NUM_ID] = '{1, 33, 65, 97, 130, 162},
    parameter logic [ID_W-1:0] ID_TABLE [NUM_REV][NUM_ID] = '{
        '{32'h1C0A_7E31, 32'h2C0A_3E31, 32'h1C0A_4E31, 32'h2C0A_5E31, 32'h1C0A_6E31, 32'h1C0A_6E31},
        '{32'h3C0A_7E31, 32'h3C0A_3E31, 32'h2C0A_4E31, 32'h3C0A_5E31, 32'h2C0A_6E31, 32'h2C0A_6E31},
        '{32'h4C0A_7E31, 32'h4C0A_3E31, 32'h3C0A_4E31, 32'h4C0A_5E31, 32'h3C0A_6E31, 32'h3C0A_6E31}
    }
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tdi,
    input  logic [REV_W-1:0]  rev,
    input  tap_ctl_t          ctl,
    output logic [DR_LEN-1:0] dr_q
);

    localparam int SEL_W = (NUM_REV > 1) ? $clog2(NUM_REV) : 1;

    logic [SEL_W-1:0]  rsel;
    logic [DR_LEN-1:0] cap_vec;

    always_comb begin
        if (int'(rev) >= NUM_REV) rsel = SEL_W'(NUM_REV - 1);
        else                      rsel = SEL_W'(rev);
    end

    // words placed most significant bit first at their start positions
    always_comb begin
        cap_vec = '0;
        for (int i = 0; i < NUM_ID; i++) begin
            for (int b = 0; b < ID_W; b++) begin
                cap_vec[ID_POS[i] + b] = ID_TABLE[rsel][i][ID_W-1-b];
            end
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            dr_q <= '0;
        else if (ctl.cap_dr)
            dr_q <= cap_vec;
        else if (ctl.sh_dr)
            dr_q <= {dr_q[DR_LEN-2:0], tdi};
    end

endmodule

// File: rtl/jtag_tap_long.sv
module jtag_tap_long
    import tap_pkg::*;
#(
    parameter int IR_LEN  = 46,
    parameter int DR_LEN  = 197,
    parameter int ID_W    = 32,
    parameter int NUM_ID  = 6,
    parameter int NUM_REV = 3,
    parameter int REV_W   = 2,
    parameter int unsigned ID_POS [NUM_ID] = '{1, 33, 65, 97, 130, 162},
    parameter logic [ID_W-1:0] ID_TABLE [NUM_REV][NUM_ID] = '{
        '{32'h1C0A_7E31, 32'h2C0A_3E31, 32'h1C0A_4E31, 32'h2C0A_5E31, 32'h1C0A_6E31, 32'h1C0A_6E31},
        '{32'h3C0A_7E31, 32'h3C0A_3E31, 32'h2C0A_4E31, 32'h3C0A_5E31, 32'h2C0A_6E31, 32'h2C0A_6E31},
        '{32'h4C0A_7E31, 32'h4C0A_3E31, 32'h3C0A_4E31, 32'h4C0A_5E31, 32'h3C0A_6E31, 32'h3C0A_6E31}
    }
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    input  logic [REV_W-1:0]  rev,
    output logic              tdo,
    output logic [3:0]        tap_state,
    output logic [IR_LEN-1:0] instr
);

    tap_state_e        state_q;
    tap_ctl_t          ctl;
    logic [IR_LEN-1:0] ir_q;
    logic [DR_LEN-1:0] dr_q;
    logic              shift_bit;
    logic              tdo_q;

    tap_fsm u_fsm (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_q (state_q),
        .ctl     (ctl)
    );

    tap_ir #(.IR_LEN(IR_LEN)) u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .tdi    (tdi),
        .ctl    (ctl),
        .ir_q   (ir_q),
        .instr  (instr)
    );

    tap_dr #(
        .DR_LEN   (DR_LEN),
        .ID_W     (ID_W),
        .NUM_ID   (NUM_ID),
        .NUM_REV  (NUM_REV),
        .REV_W    (REV_W),
        .ID_POS   (ID_POS),
        .ID_TABLE (ID_TABLE)
    ) u_dr (
        .tck    (tck),
        .trst_n (trst_n),
        .tdi    (tdi),
        .rev    (rev),
        .ctl    (ctl),
        .dr_q   (dr_q)
    );

    // bit leaving the active register on a shifting rising edge
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            shift_bit <= 1'b0;
        else if (ctl.sh_ir)
            shift_bit <= ir_q[0];
        else if (ctl.sh_dr)
            shift_bit <= dr_q[DR_LEN-1];
    end

    // output retimed to the falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) tdo_q <= 1'b0;
        else         tdo_q <= shift_bit;
    end

    assign tdo       = tdo_q;
    assign tap_state = state_q;

endmodule

// File: rtl/tap_chk.sv
module tap_chk
    import tap_pkg::*;
#(
    parameter int IR_LEN = 46,
    parameter int DR_LEN = 197
) (
    input logic              tck,
    input logic              trst_n,
    input logic              tms,
    input logic              tdi,
    input logic [3:0]        state,
    input logic [IR_LEN-1:0] ir_q,
    input logic [DR_LEN-1:0] dr_q,
    input logic [IR_LEN-1:0] instr,
    input logic              tdo
);

    a_r2_reset_hold: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TS_RESET && tms) |=> (state == TS_RESET));

    a_r2_idle_hold: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TS_IDLE && !tms) |=> (state == TS_IDLE));

    a_r3_capture_ir: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TS_CAP_IR) |-> (ir_q == IR_LEN'(1)));

    a_r4_shift_ir: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TS_SH_IR) |-> (ir_q[IR_LEN-2:0] == $past(ir_q[IR_LEN-1:1])
                                 && ir_q[IR_LEN-1] == $past(tdi)));

    a_r4_tdo_ir: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TS_SH_IR) |-> (tdo == $past(ir_q[0])));

    a_r5_instr_hold: assert property (@(posedge tck) disable iff (!trst_n)
        (state != TS_UPD_IR) |-> $stable(instr));

    a_r7_tdo_dr: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TS_SH_DR) |-> (tdo == $past(dr_q[DR_LEN-1])));

    a_r8_pause_tdo: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TS_PAU_DR) |-> $stable(tdo));

    a_r9_pause_chain: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TS_PAU_DR) |-> $stable(dr_q));

endmodule

bind jtag_tap_long tap_chk #(.IR_LEN(IR_LEN), .DR_LEN(DR_LEN)) u_chk (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .tdi    (tdi),
    .state  (tap_state),
    .ir_q   (ir_q),
    .dr_q   (dr_q),
    .instr  (instr),
    .tdo    (tdo)
);

// File: tb/sim_jtag_tap_long.sv
module sim_jtag_tap_long;

    localparam int TCK_PERIOD = 10;
    localparam int IR_LEN     = 46;
    localparam int DR_LEN     = 197;

    localparam int unsigned TB_POS [6] = '{1, 33, 65, 97, 130, 162};
    localparam logic [31:0] TB_IDS [3][6] = '{
        '{32'hA1B2_C3D4, 32'h0F1E_2D3C, 32'h8000_0001, 32'h5555_AAAA, 32'hFFFF_0000, 32'h1234_5678},
        '{32'h9ABC_DEF0, 32'hC0DE_F00D, 32'h7FFF_FFFE, 32'h0000_FFFF, 32'h3C3C_C3C3, 32'hDEAD_BEEF},
        '{32'h2468_ACE0, 32'h1357_9BDF, 32'hF0F0_0F0F, 32'h4000_0002, 32'h0123_4567, 32'h89AB_CDEF}
    };

    logic              tck = 1'b0;
    logic              trst_n = 1'b0;
    logic              tms = 1'b1;
    logic              tdi = 1'b0;
    logic [1:0]        rev = 2'd0;
    logic              tdo;
    logic [3:0]        tap_state;
    logic [IR_LEN-1:0] instr;

    jtag_tap_long #(
        .IR_LEN(IR_LEN), .DR_LEN(DR_LEN), .ID_W(32), .NUM_ID(6), .NUM_REV(3),
        .REV_W(2), .ID_POS(TB_POS), .ID_TABLE(TB_IDS)
    ) u0 (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .rev(rev),
        .tdo(tdo), .tap_state(tap_state), .instr(instr)
    );

    always #(TCK_PERIOD/2) tck = ~tck;

    typedef struct {
        int         at_cyc;
        bit         chk_st;
        logic [3:0] st;
        bit         chk_tdo;
        logic       tdo_v;
        string      req;
    } item_t;

    item_t sbq[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    logic  last_out = 1'b0;
    logic [IR_LEN-1:0] ir_model = '0;
    logic [IR_LEN-1:0] instr_model = '0;

    always @(posedge tck) cyc <= cyc + 1;

    task automatic check1(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // drive one TCK cycle and queue what it should produce
    task automatic step(input logic m, input logic d, input bit cs, input logic [3:0] es,
                        input bit ct, input logic et, input string rq);
        item_t it;
        @(negedge tck); #1;
        tms = m;
        tdi = d;
        it.at_cyc = cyc + 1;
        it.chk_st = cs; it.st = es;
        it.chk_tdo = ct; it.tdo_v = et;
        it.req = rq;
        sbq.push_back(it);
    endtask

    initial begin
        forever begin
            @(posedge tck); @(negedge tck); #2;
            while (sbq.size() > 0 && sbq[0].at_cyc <= cyc) begin
                item_t it;
                it = sbq.pop_front();
                if (it.chk_st)  check1({it.req, " state"}, 64'(tap_state), 64'(it.st));
                if (it.chk_tdo) check1({it.req, " tdo"}, 64'(tdo), 64'(it.tdo_v));
            end
        end
    end

    function automatic logic [DR_LEN-1:0] build_chain(input int r);
        logic [DR_LEN-1:0] v;
        int s;
        v = '0;
        s = (r > 2) ? 2 : r;
        for (int i = 0; i < 6; i++)
            for (int b = 0; b < 32; b++)
                v[TB_POS[i] + b] = TB_IDS[s][i][31-b];
        return v;
    endfunction

    task automatic to_reset();
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0, k == 4, 4'd0, 1'b0, 1'b0, "R2");
    endtask

    // instruction scan from Run-Test/Idle, optional pause before shift number pause_at
    task automatic ir_scan(input logic [63:0] bits, input int n, input int pause_at);
        step(1'b1, 1'b0, 1'b1, 4'd2,  1'b0, 1'b0, "R2");
        step(1'b1, 1'b0, 1'b1, 4'd9,  1'b0, 1'b0, "R2");
        step(1'b0, 1'b0, 1'b1, 4'd10, 1'b1, last_out, "R8");
        ir_model = IR_LEN'(1); // R3
        for (int k = 0; k < n; k++) begin
            logic o;
            if (k == pause_at) begin
                step(1'b1, 1'b0, 1'b1, 4'd12, 1'b1, last_out, "R9");
                step(1'b0, 1'b0, 1'b1, 4'd13, 1'b1, last_out, "R9");
                step(1'b0, 1'b0, 1'b1, 4'd13, 1'b1, last_out, "R9");
                step(1'b1, 1'b0, 1'b1, 4'd14, 1'b1, last_out, "R9");
            end
            o = ir_model[0];
            ir_model = {bits[k], ir_model[IR_LEN-1:1]};
            last_out = o;
            step(1'b0, bits[k], 1'b1, 4'd11, 1'b1, o, (k < 2) ? "R3" : "R4");
        end
        step(1'b1, 1'b0, 1'b1, 4'd12, 1'b1, last_out, "R8");
        step(1'b1, 1'b0, 1'b1, 4'd15, 1'b1, last_out, "R2");
        instr_model = ir_model;
        step(1'b0, 1'b0, 1'b1, 4'd1,  1'b0, 1'b0, "R2");
        @(negedge tck); #3;
        check1("R5 instr after update", 64'(instr), 64'(instr_model));
    endtask

    task automatic dr_scan(input int r, input int n, input logic d, input int pause_at);
        logic [DR_LEN-1:0] m;
        rev = 2'(r);
        step(1'b1, 1'b0, 1'b1, 4'd2, 1'b0, 1'b0, "R2");
        step(1'b0, 1'b0, 1'b1, 4'd3, 1'b1, last_out, "R8");
        m = build_chain(r);
        for (int k = 0; k < n; k++) begin
            logic o;
            if (k == pause_at) begin
                step(1'b1, 1'b0, 1'b1, 4'd5, 1'b1, last_out, "R9");
                step(1'b0, 1'b0, 1'b1, 4'd6, 1'b1, last_out, "R9");
                step(1'b0, 1'b0, 1'b1, 4'd6, 1'b1, last_out, "R9");
                step(1'b1, 1'b0, 1'b1, 4'd7, 1'b1, last_out, "R9");
            end
            o = m[DR_LEN-1];
            m = {m[DR_LEN-2:0], d};
            last_out = o;
            step(1'b0, d, 1'b1, 4'd4, 1'b1, o, (k < 197) ? "R6" : "R7");
        end
        step(1'b1, 1'b0, 1'b1, 4'd5, 1'b1, last_out, "R8");
        step(1'b1, 1'b0, 1'b1, 4'd8, 1'b0, 1'b0, "R2");
        step(1'b0, 1'b0, 1'b1, 4'd1, 1'b0, 1'b0, "R2");
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(TCK_PERIOD * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_up();
    end

    initial begin
        #3;
        check1("R1 reset state", 64'(tap_state), 64'd0);
        check1("R1 reset instr", 64'(instr), 64'd0);
        check1("R1 reset tdo", 64'(tdo), 64'd0);
        #19 trst_n = 1'b1;

        to_reset();
        step(1'b0, 1'b0, 1'b1, 4'd1, 1'b0, 1'b0, "R2");
        step(1'b0, 1'b0, 1'b1, 4'd1, 1'b0, 1'b0, "R2");

        ir_scan(64'hA5C3_0F96_DEAD_5A17, 50, 20);

        dr_scan(0, 200, 1'b1, 100);
        dr_scan(1, 197, 1'b1, -1);
        dr_scan(2, 197, 1'b0, 37);
        dr_scan(3, 197, 1'b1, -1);
        @(negedge tck); #3;
        check1("R5 instr kept over DR scans", 64'(instr), 64'(instr_model));

        // reset through TMS from Shift-DR keeps instr
        step(1'b1, 1'b0, 1'b1, 4'd2, 1'b0, 1'b0, "R2");
        step(1'b0, 1'b0, 1'b1, 4'd3, 1'b0, 1'b0, "R2");
        step(1'b0, 1'b0, 1'b1, 4'd4, 1'b1, 1'b0, "R7");
        step(1'b1, 1'b0, 1'b1, 4'd5, 1'b0, 1'b0, "R2");
        step(1'b1, 1'b0, 1'b1, 4'd8, 1'b0, 1'b0, "R2");
        step(1'b1, 1'b0, 1'b1, 4'd2, 1'b0, 1'b0, "R2");
        step(1'b1, 1'b0, 1'b1, 4'd9, 1'b0, 1'b0, "R2");
        step(1'b1, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0, "R2");
        step(1'b1, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0, "R2");
        @(negedge tck); #3;
        check1("R5 instr kept over TMS reset", 64'(instr), 64'(instr_model));
        last_out = 1'b0;

        step(1'b0, 1'b0, 1'b1, 4'd1, 1'b0, 1'b0, "R2");
        ir_scan(64'h0000_3FFF_0000_1C2D, 46, -1);

        // asynchronous reset in the middle of a data shift
        step(1'b1, 1'b0, 1'b1, 4'd2, 1'b0, 1'b0, "R2");
        step(1'b0, 1'b0, 1'b1, 4'd3, 1'b0, 1'b0, "R2");
        step(1'b0, 1'b1, 1'b1, 4'd4, 1'b0, 1'b0, "R2");
        step(1'b0, 1'b1, 1'b1, 4'd4, 1'b0, 1'b0, "R2");
        @(negedge tck); @(negedge tck); #3;
        trst_n = 1'b0;
        #1;
        check1("R1 async state", 64'(tap_state), 64'd0);
        check1("R1 async instr", 64'(instr), 64'd0);
        check1("R1 async tdo", 64'(tdo), 64'd0);
        @(negedge tck); @(negedge tck); #3;
        trst_n = 1'b1;
        last_out = 1'b0;
        instr_model = '0;

        step(1'b0, 1'b0, 1'b1, 4'd1, 1'b0, 1'b0, "R2");
        dr_scan(1, 40, 1'b0, -1);

        @(negedge tck); @(negedge tck); @(negedge tck); #3;
        finish_up();
    end

endmodule